// File: doc/BRIEF.md
# Per-CPU Highest-Priority Pending Interrupt Selector

This block picks, for every processor in a multi-core cluster, the one interrupt it should be offered next. It looks at a parameterised set of interrupt sources. Each source carries a priority, and the lower value is the more urgent. Each source also has an enable bit and a pending bit per processor, and each shared source has a target mask. For each processor the block finds the most urgent source that is enabled, pending and aimed at that processor. The lowest ID breaks a tie.

The winner then passes through two thresholds. The processor's priority mask decides whether the winner is published at all as that processor's pending ID. The processor's running priority separately decides whether the interrupt request line to that processor is raised. Group enables at the cluster level and at the processor level can silence a processor completely. When nothing qualifies, the published ID is the spurious code 1023.

The selection is a balanced comparator tree per processor, and its result is registered. Every output therefore reflects the inputs sampled at the previous clock edge.

Top module: `prio_pend_sel`

## Requirements
- R1: Among the candidates for a processor, the source with the numerically lowest 8-bit priority is selected.
- R2: When a processor has no candidate, its pending ID (bits `[c*10 +: 10]` of `cpu_pend_id`) is 1023 and its request line is low.
- R3: Source s counts for processor c only if both `src_en[c*NUM_SRC+s]` and `src_pend[c*NUM_SRC+s]` are 1; the bits that belong to other processors have no effect.
- R4: Sources with ID below 32 are private and ignore targeting. A shared source s (ID 32 or above) counts for processor c only if `shr_tgt[(s-32)*NUM_CPU+c]` is 1.
- R5: The winner's ID is published only if its priority is strictly less than the processor's mask (`cpu_mask[c*8 +: 8]`); otherwise the ID is 1023 and the request line is low.
- R6: The request line rises only for a published winner whose priority, zero-extended to 9 bits, is strictly less than the processor's running priority (`cpu_run[c*9 +: 9]`, where 0x100 means idle). A published winner that fails this test keeps its ID on the output.
- R7: If both bits of `dist_grp_en` are 0, or both bits of the processor's `cpu_grp_en[c*2 +: 2]` are 0, that processor shows ID 1023 and a low request line.
- R8: Between candidates of equal priority, the lower source ID wins.
- R9: Outputs change one clock after the inputs that cause them. While reset is high, every pending ID is 1023 and every request line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_en | input | NUM_CPU*NUM_SRC | Enable bit per processor and source, processor-major |
| src_pend | input | NUM_CPU*NUM_SRC | Pending bit per processor and source, processor-major |
| shr_tgt | input | (NUM_SRC-32)*NUM_CPU | Target mask of each shared source, source-major |
| src_prio | input | NUM_SRC*8 | Priority of each source, lower is more urgent |
| dist_grp_en | input | 2 | Cluster-wide group enables |
| cpu_grp_en | input | NUM_CPU*2 | Group enables per processor |
| cpu_mask | input | NUM_CPU*8 | Priority mask per processor |
| cpu_run | input | NUM_CPU*9 | Running priority per processor, 0x100 when idle |
| cpu_req | output | NUM_CPU | Interrupt request line per processor |
| cpu_pend_id | output | NUM_CPU*10 | Published pending ID per processor, 1023 when none |

## Verification
Assertions run on every cycle. Inside the comparator tree, they check that no valid leaf is more urgent than the winner and that a tie never resolves to a higher ID. At the output stage, they check that a raised request always comes with a real ID, that a published ID was strictly under the previous cycle's mask, that a raised request was strictly under the previous running priority, and that a disabled group silences the processor one cycle later. The bench scenarios add what the assertions cannot see: that the winner is the correct source once per-processor enables, pending bits and target masks are combined, that the boundary cases where priority equals the mask or the running priority block the output, and that each processor is independent of the others.

// File: rtl/pps_pkg.sv
package pps_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] SPUR_ID = 10'd1023;
  localparam int PRIV_SRC = 32;
endpackage

// File: rtl/pps_cand.sv
module pps_cand #(
  parameter int NUM_SRC  = 64,
  parameter int NUM_CPU  = 2,
  parameter int PRIV_CNT = 32,
  parameter int CPU_IDX  = 0
) (
  input  logic [NUM_SRC-1:0]                   en,
  input  logic [NUM_SRC-1:0]                   pend,
  input  logic [(NUM_SRC-PRIV_CNT)*NUM_CPU-1:0] tgt,
  output logic [NUM_SRC-1:0]                   cand
);
  // Private sources bypass targeting; shared ones need this CPU's target bit.
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    if (s < PRIV_CNT) begin : g_priv
      assign cand[s] = en[s] & pend[s];
    end else begin : g_shr
      assign cand[s] = en[s] & pend[s] & tgt[(s-PRIV_CNT)*NUM_CPU + CPU_IDX];
    end
  end
endmodule

// File: rtl/pps_argmin.sv
module pps_argmin #(
  parameter int N  = 64,
  parameter int PW = 8,
  localparam int LV = $clog2(N),
  localparam int P  = 1 << LV
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]    in_v,
  input  logic [N*PW-1:0] in_p,
  output logic           out_v,
  output logic [PW-1:0]  out_p,
  output logic [LV-1:0]  out_id
);
  // Level 0 holds the leaves; each higher level halves the width.
  // The left child always covers lower IDs, so taking left on equal
  // priority gives the lower-ID tie break.
  for (genvar l = 0; l <= LV; l++) begin : g_lvl
    localparam int W = P >> l;
    logic [W-1:0]         v;
    logic [W-1:0][PW-1:0] p;
    logic [W-1:0][LV-1:0] id;
    if (l == 0) begin : g_leaf
      for (genvar k = 0; k < W; k++) begin : g_k
        if (k < N) begin : g_real
          assign v[k]  = in_v[k];
          assign p[k]  = in_p[k*PW +: PW];
          assign id[k] = LV'(k);
        end else begin : g_pad
          assign v[k]  = 1'b0;
          assign p[k]  = '1;
          assign id[k] = LV'(k);
        end
      end
    end else begin : g_node
      for (genvar k = 0; k < W; k++) begin : g_k
        logic take_l;
        assign take_l = g_lvl[l-1].v[2*k] &&
                        (!g_lvl[l-1].v[2*k+1] ||
                         (g_lvl[l-1].p[2*k] <= g_lvl[l-1].p[2*k+1]));
        assign v[k]  = g_lvl[l-1].v[2*k] | g_lvl[l-1].v[2*k+1];
        assign p[k]  = take_l ? g_lvl[l-1].p[2*k]  : g_lvl[l-1].p[2*k+1];
        assign id[k] = take_l ? g_lvl[l-1].id[2*k] : g_lvl[l-1].id[2*k+1];
      end
    end
  end

  assign out_v  = g_lvl[LV].v[0];
  assign out_p  = g_lvl[LV].p[0];
  assign out_id = g_lvl[LV].id[0];

  for (genvar k = 0; k < N; k++) begin : g_chk
    // R1: no valid leaf is more urgent than the winner
    p_leaf_not_better_r1: assert property (@(posedge clk) disable iff (rst)
      in_v[k] |-> (out_v && (out_p <= in_p[k*PW +: PW])));
    // R8: an equal-priority leaf never has a lower ID than the winner
    p_tie_low_id_r8: assert property (@(posedge clk) disable iff (rst)
      (in_v[k] && (in_p[k*PW +: PW] == out_p)) |-> (out_id <= LV'(k)));
  end
endmodule

// File: rtl/pps_gate.sv
module pps_gate
  import pps_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            win_v,
  input  logic [PW-1:0]   win_p,
  input  logic [ID_W-1:0] win_id,
  input  logic [1:0]      grp_dist,
  input  logic [1:0]      grp_cpu,
  input  logic [PW-1:0]   mask,
  input  logic [PW:0]     run,
  output logic            req,
  output logic [ID_W-1:0] id
);
  logic grp_on;
  logic publish;
  logic beats_run;

  assign grp_on    = (|grp_dist) && (|grp_cpu);
  assign publish   = grp_on && win_v && (win_p < mask);
  assign beats_run = ({1'b0, win_p} < run);

  always_ff @(posedge clk) begin
    if (rst) begin
      req <= 1'b0;
      id  <= SPUR_ID;
    end else begin
      id  <= publish ? win_id : SPUR_ID;
      req <= publish && beats_run;
    end
  end

  // R6: a raised request always carries a published ID
  p_req_has_id_r6: assert property (@(posedge clk) disable iff (rst)
    req |-> (id != SPUR_ID));
  // R5: a published ID was strictly under the mask one cycle earlier
  p_mask_strict_r5: assert property (@(posedge clk) disable iff (rst)
    (id != SPUR_ID) |-> ($past(win_p) < $past(mask)));
  // R6: a raised request was strictly under the running priority
  p_run_strict_r6: assert property (@(posedge clk) disable iff (rst)
    req |-> ({1'b0, $past(win_p)} < $past(run)));
  // R7: disabled groups silence the CPU on the next cycle
  p_grp_off_r7: assert property (@(posedge clk) disable iff (rst)
    (!(|grp_dist) || !(|grp_cpu)) |=> (!req && (id == SPUR_ID)));
endmodule

// File: rtl/prio_pend_sel.sv
module prio_pend_sel
  import pps_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 2,
  parameter int PRIO_W  = 8
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [NUM_CPU*NUM_SRC-1:0]          src_en,
  input  logic [NUM_CPU*NUM_SRC-1:0]          src_pend,
  input  logic [(NUM_SRC-PRIV_SRC)*NUM_CPU-1:0] shr_tgt,
  input  logic [NUM_SRC*PRIO_W-1:0]           src_prio,
  input  logic [1:0]                          dist_grp_en,
  input  logic [NUM_CPU*2-1:0]                cpu_grp_en,
  input  logic [NUM_CPU*PRIO_W-1:0]           cpu_mask,
  input  logic [NUM_CPU*(PRIO_W+1)-1:0]       cpu_run,
  output logic [NUM_CPU-1:0]                  cpu_req,
  output logic [NUM_CPU*ID_W-1:0]             cpu_pend_id
);
  localparam int LV = $clog2(NUM_SRC);

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_SRC-1:0] cand;
    logic               w_v;
    logic [PRIO_W-1:0]  w_p;
    logic [LV-1:0]      w_id;
    logic [ID_W-1:0]    pid;

    pps_cand #(
      .NUM_SRC (NUM_SRC),
      .NUM_CPU (NUM_CPU),
      .PRIV_CNT(PRIV_SRC),
      .CPU_IDX (c)
    ) u_cand (
      .en  (src_en[c*NUM_SRC +: NUM_SRC]),
      .pend(src_pend[c*NUM_SRC +: NUM_SRC]),
      .tgt (shr_tgt),
      .cand(cand)
    );

    pps_argmin #(
      .N (NUM_SRC),
      .PW(PRIO_W)
    ) u_tree (
      .clk   (clk),
      .rst   (rst),
      .in_v  (cand),
      .in_p  (src_prio),
      .out_v (w_v),
      .out_p (w_p),
      .out_id(w_id)
    );

    pps_gate #(
      .PW(PRIO_W)
    ) u_gate (
      .clk     (clk),
      .rst     (rst),
      .win_v   (w_v),
      .win_p   (w_p),
      .win_id  ({{(ID_W-LV){1'b0}}, w_id}),
      .grp_dist(dist_grp_en),
      .grp_cpu (cpu_grp_en[c*2 +: 2]),
      .mask    (cpu_mask[c*PRIO_W +: PRIO_W]),
      .run     (cpu_run[c*(PRIO_W+1) +: (PRIO_W+1)]),
      .req     (cpu_req[c]),
      .id      (pid)
    );

    assign cpu_pend_id[c*ID_W +: ID_W] = pid;

    // R2: the published ID is either spurious or a real source number
    p_id_range_r2: assert property (@(posedge clk) disable iff (rst)
      (pid == SPUR_ID) || (pid < ID_W'(NUM_SRC)));
  end
endmodule

// File: tb/sim_prio_pend_sel.sv
module sim_prio_pend_sel;
  localparam int NS  = 64;
  localparam int NC  = 2;
  localparam int NSH = NS - 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NC*NS-1:0]  en   = '0;
  logic [NC*NS-1:0]  pend = '0;
  logic [NSH*NC-1:0] tgt  = '0;
  logic [NS*8-1:0]   prio = '0;
  logic [1:0]        dgrp = 2'b01;
  logic [NC*2-1:0]   cgrp = '0;
  logic [NC*8-1:0]   mask = '0;
  logic [NC*9-1:0]   run  = '0;
  logic [NC-1:0]     req;
  logic [NC*10-1:0]  pid;

  int checks = 0;
  int fails  = 0;
  int exp_id  [NC];
  bit exp_req [NC];

  always #4 clk = ~clk;

  prio_pend_sel #(.NUM_SRC(NS), .NUM_CPU(NC), .PRIO_W(8)) u0 (
    .clk(clk), .rst(rst), .src_en(en), .src_pend(pend), .shr_tgt(tgt),
    .src_prio(prio), .dist_grp_en(dgrp), .cpu_grp_en(cgrp),
    .cpu_mask(mask), .cpu_run(run), .cpu_req(req), .cpu_pend_id(pid));

  // Behavioural reference: ascending scan with strict less-than.
  task automatic model();
    for (int c = 0; c < NC; c++) begin
      int best = 256;
      int bid  = 1023;
      for (int s = 0; s < NS; s++) begin
        bit tv = 1'b1;
        if (s >= 32) tv = tgt[(s-32)*NC + c];
        if (en[c*NS+s] && pend[c*NS+s] && tv && (int'(prio[s*8 +: 8]) < best)) begin
          best = int'(prio[s*8 +: 8]);
          bid  = s;
        end
      end
      exp_id[c]  = 1023;
      exp_req[c] = 1'b0;
      if ((dgrp != 0) && (cgrp[c*2 +: 2] != 0) && (best < int'(mask[c*8 +: 8]))) begin
        exp_id[c]  = bid;
        exp_req[c] = (best < int'(run[c*9 +: 9]));
      end
    end
  endtask

  task automatic check_outs(string tag);
    for (int c = 0; c < NC; c++) begin
      checks++;
      if (int'(pid[c*10 +: 10]) != exp_id[c]) begin
        fails++;
        $display("FAIL %s cpu%0d id: got %0d expected %0d", tag, c, pid[c*10 +: 10], exp_id[c]);
      end
      checks++;
      if (req[c] !== exp_req[c]) begin
        fails++;
        $display("FAIL %s cpu%0d req: got %0b expected %0b", tag, c, req[c], exp_req[c]);
      end
    end
  endtask

  // Inputs are set just after a falling edge; the next falling edge sees the result (R9).
  task automatic step(string tag);
    model();
    @(negedge clk);
    check_outs(tag);
  endtask

  task automatic src(int c, int s, bit e, bit p);
    en[c*NS+s]   = e;
    pend[c*NS+s] = p;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(8*200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int s = 0; s < NS; s++) prio[s*8 +: 8] = 8'h80;
    for (int c = 0; c < NC; c++) begin
      cgrp[c*2 +: 2] = 2'b01;
      mask[c*8 +: 8] = 8'hFF;
      run[c*9 +: 9]  = 9'h100;
    end
    // R9: reset holds spurious ID and low request despite a live candidate
    src(0, 7, 1, 1);
    repeat (3) @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      exp_id[c] = 1023; exp_req[c] = 1'b0;
    end
    check_outs("R9");
    rst = 1'b0;
    src(0, 7, 0, 0);
    step("R9");

    // R2: nothing pending anywhere
    step("R2");

    // R1: lowest priority value wins
    prio[5*8 +: 8] = 8'h40; src(0, 5, 1, 1);
    prio[10*8 +: 8] = 8'h20; src(0, 10, 1, 1);
    prio[40*8 +: 8] = 8'h30; src(0, 40, 1, 1); tgt[(40-32)*NC + 0] = 1'b1;
    step("R1");

    // R8: equal priorities, lower ID wins
    prio[5*8 +: 8] = 8'h20;
    step("R8");

    // R4: shared source aimed only at cpu1
    prio[40*8 +: 8] = 8'h10;
    tgt[(40-32)*NC + 0] = 1'b0; tgt[(40-32)*NC + 1] = 1'b1;
    src(1, 40, 1, 1);
    step("R4");
    // R4: private source needs no target
    src(1, 3, 1, 1); prio[3*8 +: 8] = 8'h08;
    step("R4");
    // R4: highest shared ID
    src(1, 3, 0, 0); src(1, 40, 0, 0);
    src(1, 63, 1, 1); prio[63*8 +: 8] = 8'h01; tgt[(63-32)*NC + 1] = 1'b1;
    step("R4");

    // R3: pending without enable, and other CPU's bits, have no effect
    src(1, 63, 0, 1);
    src(1, 20, 1, 0);
    step("R3");
    src(1, 63, 0, 0); src(1, 20, 0, 0);

    // R5: winner priority equal to mask blocks publishing
    mask[0*8 +: 8] = 8'h20;
    step("R5");
    mask[0*8 +: 8] = 8'h21;
    step("R5");

    // R6: equal running priority keeps ID but drops request
    run[0*9 +: 9] = 9'h020;
    step("R6");
    run[0*9 +: 9] = 9'h021;
    step("R6");
    run[0*9 +: 9] = 9'h100; mask[0*8 +: 8] = 8'hFF;

    // R7: group enables
    src(1, 12, 1, 1);
    dgrp = 2'b00;
    step("R7");
    dgrp = 2'b10;
    step("R7");
    cgrp[0*2 +: 2] = 2'b00;
    step("R7");
    cgrp[0*2 +: 2] = 2'b11;
    step("R7");

    // R1: randomised mix, ties and thresholds included
    for (int n = 0; n < 400; n++) begin
      for (int i = 0; i < NC*NS; i++) begin
        en[i]   = ($urandom % 4) != 0;
        pend[i] = ($urandom % 8) == 0;
      end
      for (int i = 0; i < NSH*NC; i++) tgt[i] = $urandom % 2;
      for (int s = 0; s < NS; s++) prio[s*8 +: 8] = 8'(($urandom % 6) * 8'h28);
      dgrp = (($urandom % 10) == 0) ? 2'b00 : 2'(($urandom % 3) + 1);
      for (int c = 0; c < NC; c++) begin
        cgrp[c*2 +: 2] = (($urandom % 10) == 0) ? 2'b00 : 2'(($urandom % 3) + 1);
        mask[c*8 +: 8] = 8'(8'h40 + ($urandom % 192));
        run[c*9 +: 9]  = (($urandom % 3) == 0) ? 9'h100 : 9'($urandom % 256);
      end
      step("R1");
    end

    finish_run();
  end
endmodule